// File: doc/BRIEF.md
# Cache Region Maintenance Sequencer

This block turns one cache maintenance command into a stream of per-line operations for a line maintenance unit. For a region command it takes a start address and a byte length, works out how many cache lines the byte range touches, and issues one hit-type operation per line at line-aligned addresses. For a whole-cache command it walks every set index in groups of four consecutive lines. A reset command runs an unlock walk and then an invalidate walk.

Each command finishes in the same way. Once the last line operation has been acknowledged, the block raises a sync request. It waits for the sync acknowledge and then pulses done. A command is taken only while the block is idle. The cache geometry comes from parameters, and a geometry that the four-line walk cannot cover exactly is reported on a static flag.

Top module: `cmaint_seq`

## Requirements
- R1: A region command (cmd_mode = 0) issues exactly (cmd_len + (cmd_addr mod LINE_BYTES) + LINE_BYTES - 1) / LINE_BYTES line operations, rounded down. The first operation is at cmd_addr with its low log2(LINE_BYTES) bits cleared. Each later operation is at the previous address plus LINE_BYTES. Each carries lop_code = cmd_code and lop_indexed = 0.
- R2: A region command whose computed line count is zero issues no line operation and proceeds straight to the sync step.
- R3: A whole-cache command touching every way (cmd_mode = 1) runs CACHE_BYTES / (LINE_BYTES * NUM_WAYS * 4) groups. Each group issues four operations at group base + 0, 1, 2 and 3 times LINE_BYTES, and the base then advances by 4 * LINE_BYTES, starting from 0. All carry lop_indexed = 1 and lop_code = cmd_code.
- R4: A whole-cache command touching one way (cmd_mode = 2) walks in the same way, but with CACHE_BYTES / (LINE_BYTES * 4) groups.
- R5: cfg_err is high when CACHE_BYTES is not a non-zero multiple of LINE_BYTES * NUM_WAYS * 4 or of LINE_BYTES * 4. A whole-cache walk whose own geometry is illegal issues no line operations.
- R6: A reset command (cmd_mode = 3) runs a one-way walk (as in R4) with lop_code = RST_UNLOCK_CODE (default 4'hA). It then runs an every-way walk (as in R3) with lop_code = RST_INVAL_CODE (default 4'h5).
- R7: The sync request rises only after the last line operation is acknowledged. It stays high until sync_ack. lop_req and sync_req are never high together.
- R8: done pulses for exactly one cycle, on the edge after the one where sync_ack is sampled. busy is low while done is high.
- R9: A command is accepted only when busy is low, and busy is high on the cycle after acceptance. cmd_valid while busy is ignored and adds no line operation.
- R10: While lop_req is high and lop_ack is low, lop_req, lop_addr and lop_code hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_mode | input | 2 | 0 region, 1 all ways, 2 one way, 3 reset |
| cmd_code | input | OP_W | Operation code forwarded on each line operation |
| cmd_addr | input | ADDR_W | Region start address |
| cmd_len | input | LEN_W | Region length in bytes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Geometry not covered by the four-line walk |
| lop_req | output | 1 | Line operation request |
| lop_ack | input | 1 | Line operation acknowledge |
| lop_addr | output | ADDR_W | Line address or set index address |
| lop_code | output | OP_W | Operation code of the current request |
| lop_indexed | output | 1 | 1 for whole-cache index walks, 0 for hit operations |
| sync_req | output | 1 | Sync request after the last line operation |
| sync_ack | input | 1 | Sync complete |

## Verification
The bench targets the rounding in the line count. It uses unaligned starts whose tail spills into one more line, a zero length at an unaligned address (which still touches one line) and a zero length at an aligned address (which touches none). A design that forgets the misalignment term or the round-up issues one operation too few or too many, and the scoreboard sees the count mismatch. The reset command is checked to switch from the unlock code to the invalidate code exactly at the walk boundary, with the every-way iteration count. A stray command is pulsed mid-walk, so a design that accepts it while busy would emit extra operations. Irregular acknowledge gaps expose requests whose address changes before they are acknowledged, and a sync raised before the last acknowledge.

// File: rtl/cmaint_pkg.sv
// Shared types for the cache maintenance sequencer.
package cmaint_pkg;

    // Command mode encoding, as seen on cmd_mode.
    typedef enum logic [1:0] {
        MODE_REGION    = 2'd0,
        MODE_ALL_EVERY = 2'd1,
        MODE_ALL_ONE   = 2'd2,
        MODE_RESET     = 2'd3
    } cm_mode_e;

    // Sequencer control states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINE = 2'd1,
        ST_SYNC = 2'd2
    } cm_state_e;

endpackage

// File: rtl/cmaint_linecnt.sv
// Line-count unit.
// Computes the number of lines a byte range touches. An unaligned start
// adds its offset before the round-up. Also provides the whole-cache
// group count for the selected way scope and the static geometry checks.
// Assumes LINE_BYTES is a power of two.
module cmaint_linecnt #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int LINE_BYTES  = 16,
    parameter int CACHE_BYTES = 1024,
    parameter int NUM_WAYS    = 4,
    localparam int LOG2L      = $clog2(LINE_BYTES),
    localparam int CNT_W      = LEN_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              sel_every,
    output logic [CNT_W-1:0]  region_cnt,
    output logic [CNT_W-1:0]  walk_groups,
    output logic              cfg_err
);
    localparam int GRP_EVERY = LINE_BYTES * NUM_WAYS * 4;
    localparam int GRP_ONE   = LINE_BYTES * 4;
    localparam int N_EVERY   = CACHE_BYTES / GRP_EVERY;
    localparam int N_ONE     = CACHE_BYTES / GRP_ONE;
    localparam bit OK_EVERY  = ((CACHE_BYTES % GRP_EVERY) == 0) && (N_EVERY > 0);
    localparam bit OK_ONE    = ((CACHE_BYTES % GRP_ONE) == 0) && (N_ONE > 0);

    logic [CNT_W-1:0] span;

    // Region span plus round-up, then divide by the line size.
    always_comb begin
        span       = {1'b0, len} + CNT_W'(addr[LOG2L-1:0]) + CNT_W'(LINE_BYTES - 1);
        region_cnt = span >> LOG2L;
    end

    // Whole-cache group count; an illegal geometry yields zero groups.
    always_comb begin
        if (sel_every) walk_groups = OK_EVERY ? CNT_W'(N_EVERY) : '0;
        else           walk_groups = OK_ONE   ? CNT_W'(N_ONE)   : '0;
    end

    assign cfg_err = !(OK_EVERY && OK_ONE);

endmodule

// File: rtl/cmaint_addrgen.sv
// Address generator.
// In hit mode it steps a line-aligned address by one line per operation.
// In walk mode it issues four offsets per group from a group base and
// advances the base by four lines after the fourth. The counter holds
// lines (hit mode) or groups (walk mode) still to issue.
// Assumes load is never raised with a zero count while output is in use.
module cmaint_addrgen #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 17,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_walk,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int GROUP = 4;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        sub_q;
    logic [CNT_W-1:0]  left_q;
    logic              walk_q;
    logic [ADDR_W-1:0] offs [GROUP];

    // Offset table of the four lines of a group.
    for (genvar j = 0; j < GROUP; j++) begin : g_offs
        assign offs[j] = ADDR_W'(j * LINE_BYTES);
    end

    // Current address and last-operation flag.
    always_comb begin
        addr = walk_q ? base_q + offs[sub_q] : base_q;
        last = walk_q ? (left_q == CNT_W'(1) && sub_q == 2'd3)
                      : (left_q == CNT_W'(1));
    end

    // Load, then advance on every acknowledged operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            sub_q  <= '0;
            left_q <= '0;
            walk_q <= 1'b0;
        end else if (load) begin
            base_q <= load_base;
            sub_q  <= '0;
            left_q <= load_cnt;
            walk_q <= load_walk;
        end else if (step) begin
            if (walk_q) begin
                if (sub_q == 2'd3) begin
                    sub_q  <= '0;
                    base_q <= base_q + ADDR_W'(GROUP * LINE_BYTES);
                    left_q <= left_q - CNT_W'(1);
                end else begin
                    sub_q <= sub_q + 2'd1;
                end
            end else begin
                base_q <= base_q + ADDR_W'(LINE_BYTES);
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/cmaint_seq.sv
// Cache region maintenance sequencer (top).
// Accepts one command while idle and issues its line operations over a
// request/acknowledge port. It then requests a sync, and pulses done
// once the sync is acknowledged. A reset command chains an unlock walk
// and an invalidate walk. Assumes lop_ack and sync_ack are only
// meaningful while the matching request is high.
module cmaint_seq #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int OP_W        = 4,
    parameter int LINE_BYTES  = 16,
    parameter int CACHE_BYTES = 1024,
    parameter int NUM_WAYS    = 4,
    parameter logic [OP_W-1:0] RST_UNLOCK_CODE = 4'hA,
    parameter logic [OP_W-1:0] RST_INVAL_CODE  = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_mode,
    input  logic [OP_W-1:0]   cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              lop_req,
    input  logic              lop_ack,
    output logic [ADDR_W-1:0] lop_addr,
    output logic [OP_W-1:0]   lop_code,
    output logic              lop_indexed,
    output logic              sync_req,
    input  logic              sync_ack
);
    import cmaint_pkg::*;

    localparam int LOG2L = $clog2(LINE_BYTES);
    localparam int CNT_W = LEN_W + 1;

    cm_state_e         state_q;
    cm_mode_e          mode_in;
    logic [OP_W-1:0]   code_q;
    logic              walk_q, is_reset_q, phase2_q, done_q;
    logic              accept, step, op_last, sel_every, switch_walk;
    logic              ld, ld_walk;
    logic [ADDR_W-1:0] ld_base;
    logic [CNT_W-1:0]  ld_cnt, region_cnt, walk_groups;

    assign mode_in = cm_mode_e'(cmd_mode);

    cmaint_linecnt #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES),
        .CACHE_BYTES(CACHE_BYTES), .NUM_WAYS(NUM_WAYS)
    ) u_linecnt (
        .addr(cmd_addr), .len(cmd_len), .sel_every(sel_every),
        .region_cnt(region_cnt), .walk_groups(walk_groups), .cfg_err(cfg_err)
    );

    cmaint_addrgen #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)
    ) u_addrgen (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_walk(ld_walk),
        .load_base(ld_base), .load_cnt(ld_cnt), .step(step),
        .addr(lop_addr), .last(op_last)
    );

    // Handshake and port outputs.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        lop_req     = (state_q == ST_LINE);
        sync_req    = (state_q == ST_SYNC);
        lop_code    = code_q;
        lop_indexed = walk_q;
        done        = done_q;
        accept      = cmd_valid && (state_q == ST_IDLE);
        step        = lop_req && lop_ack;
        switch_walk = step && op_last && is_reset_q && !phase2_q;
    end

    // Selection of what the address generator loads, and when.
    always_comb begin
        sel_every = (state_q == ST_IDLE) ? (mode_in == MODE_ALL_EVERY) : 1'b1;
        ld        = accept || switch_walk;
        if (state_q == ST_IDLE && mode_in == MODE_REGION) begin
            ld_walk = 1'b0;
            ld_base = {cmd_addr[ADDR_W-1:LOG2L], LOG2L'(0)};
            ld_cnt  = region_cnt;
        end else begin
            ld_walk = 1'b1;
            ld_base = '0;
            ld_cnt  = walk_groups;
        end
    end

    // Control state machine: idle, issue lines, sync, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            code_q     <= '0;
            walk_q     <= 1'b0;
            is_reset_q <= 1'b0;
            phase2_q   <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    code_q     <= (mode_in == MODE_RESET) ? RST_UNLOCK_CODE : cmd_code;
                    walk_q     <= (mode_in != MODE_REGION);
                    is_reset_q <= (mode_in == MODE_RESET);
                    phase2_q   <= 1'b0;
                    state_q    <= (ld_cnt == '0) ? ST_SYNC : ST_LINE;
                end
                ST_LINE: if (switch_walk) begin
                    phase2_q <= 1'b1;
                    code_q   <= RST_INVAL_CODE;
                    state_q  <= (ld_cnt == '0) ? ST_SYNC : ST_LINE;
                end else if (step && op_last) begin
                    state_q <= ST_SYNC;
                end
                ST_SYNC: if (sync_ack) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lop_req && !lop_ack) |=> (lop_req && $stable(lop_addr) && $stable(lop_code))); // R10
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(lop_req && sync_req)); // R7
    AST_DONE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sync_req && sync_ack)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy); // R9
    AST_HIT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (lop_req && !lop_indexed) |-> (lop_addr[LOG2L-1:0] == '0)); // R1
    AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !lop_indexed && !op_last) |=>
        (lop_req && lop_addr == $past(lop_addr) + ADDR_W'(LINE_BYTES))); // R1

endmodule

// File: tb/cmaint_seq_bench.sv
// Scoreboard bench: the driver queues the expected line operations, and the
// monitor acknowledges with varying gaps and compares each one.
module cmaint_seq_bench;
    localparam int ADDR_W = 32, LEN_W = 16, OP_W = 4;
    localparam int LB = 16, CB = 1024, NW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_mode = '0;
    logic [OP_W-1:0] cmd_code = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic lop_ack = 1'b0, sync_ack = 1'b0;
    logic busy, done, cfg_err, lop_req, lop_indexed, sync_req;
    logic [ADDR_W-1:0] lop_addr;
    logic [OP_W-1:0] lop_code;
    logic b_busy, b_done, b_cfg_err, b_lreq, b_lidx, b_sreq;
    logic [ADDR_W-1:0] b_laddr;
    logic [OP_W-1:0] b_lcode;

    int n_checks = 0, n_fail = 0, sync_seen = 0, gap_seq = 0, wait_cnt = 0, swait = 0;
    int cycles = 0;
    string cur_tag = "R1";
    logic [ADDR_W+OP_W:0] exp_q [$];
    logic hold_chk = 1'b0;
    logic [ADDR_W-1:0] held_addr;
    logic [OP_W-1:0] held_code;

    always #5 clk = ~clk;

    cmaint_seq u_cmaint_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .busy(busy), .done(done), .cfg_err(cfg_err), .lop_req(lop_req),
        .lop_ack(lop_ack), .lop_addr(lop_addr), .lop_code(lop_code),
        .lop_indexed(lop_indexed), .sync_req(sync_req), .sync_ack(sync_ack)
    );

    cmaint_seq #(.CACHE_BYTES(768), .NUM_WAYS(8)) u_cmaint_seq_bad (
        .clk(clk), .rst_n(rst_n), .cmd_valid(1'b0), .cmd_mode(2'd0),
        .cmd_code(4'h0), .cmd_addr(32'h0), .cmd_len(16'h0),
        .busy(b_busy), .done(b_done), .cfg_err(b_cfg_err), .lop_req(b_lreq),
        .lop_ack(1'b0), .lop_addr(b_laddr), .lop_code(b_lcode),
        .lop_indexed(b_lidx), .sync_req(b_sreq), .sync_ack(1'b0)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    // Monitor: acknowledges line ops and the sync, and pops and compares.
    always @(negedge clk) begin
        lop_ack  = 1'b0;
        sync_ack = 1'b0;
        if (hold_chk) begin
            check("R10 hold", {lop_req, lop_code, lop_addr}, {1'b1, held_code, held_addr});
            hold_chk = 1'b0;
        end
        if (rst_n && lop_req) begin
            if (wait_cnt == 0) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected op", {lop_code, lop_addr}, '1);
                end else begin
                    logic [ADDR_W+OP_W:0] e;
                    e = exp_q.pop_front();
                    check(cur_tag, {lop_indexed, lop_code, lop_addr}, e);
                end
                lop_ack  = 1'b1;
                gap_seq  = (gap_seq + 1) % 3;
                wait_cnt = gap_seq;
            end else begin
                wait_cnt--;
                hold_chk  = 1'b1;
                held_addr = lop_addr;
                held_code = lop_code;
            end
        end
        if (rst_n && sync_req) begin
            if (swait == 0) begin
                check("R7 sync after last op", exp_q.size(), 0);
                check("R7 no overlap", lop_req, 0);
                sync_ack = 1'b1;
                sync_seen++;
                swait = 2;
            end else swait--;
        end
    end

    // Driver: queues the expected ops, then issues the command.
    task automatic run_cmd(input logic [1:0] mode, input logic [OP_W-1:0] code,
                           input logic [ADDR_W-1:0] addr, input logic [LEN_W-1:0] len,
                           input string tag, input bit stray);
        int n;
        logic [ADDR_W-1:0] base;
        cur_tag = tag;
        sync_seen = 0;
        if (mode == 2'd0) begin
            n = (int'(len) + int'(addr % LB) + LB - 1) / LB;
            base = addr & ~32'(LB - 1);
            for (int k = 0; k < n; k++) exp_q.push_back({1'b0, code, base + 32'(k * LB)});
        end else if (mode == 2'd1) begin
            for (int k = 0; k < 4 * (CB / (LB * NW * 4)); k++) exp_q.push_back({1'b1, code, 32'(k * LB)});
        end else if (mode == 2'd2) begin
            for (int k = 0; k < 4 * (CB / (LB * 4)); k++) exp_q.push_back({1'b1, code, 32'(k * LB)});
        end else begin
            for (int k = 0; k < 4 * (CB / (LB * 4)); k++) exp_q.push_back({1'b1, 4'hA, 32'(k * LB)});
            for (int k = 0; k < 4 * (CB / (LB * NW * 4)); k++) exp_q.push_back({1'b1, 4'h5, 32'(k * LB)});
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = mode; cmd_code = code; cmd_addr = addr; cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 busy after accept", busy, 1);
        if (stray) begin
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1; cmd_mode = 2'd0; cmd_addr = 32'h8000; cmd_len = 16'd64;
            @(negedge clk);
            cmd_valid = 1'b0;
            check("R9 still busy", busy, 1);
        end
        while (!done) @(negedge clk);
        check("R8 busy low with done", busy, 0);
        check({tag, " all ops seen"}, exp_q.size(), 0);
        check("R7 one sync", sync_seen, 1);
        @(negedge clk);
        check("R8 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        check("R9 idle after done", {lop_req, sync_req}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset busy", busy, 0);
        check("R7 reset reqs", {lop_req, sync_req, done}, 0);
        check("R5 legal geometry", cfg_err, 0);
        check("R5 illegal geometry", b_cfg_err, 1);
        run_cmd(2'd0, 4'h3, 32'h1000, 16'd64, "R1 aligned", 0);
        run_cmd(2'd0, 4'h3, 32'h1004, 16'd64, "R1 unaligned", 0);
        run_cmd(2'd0, 4'h7, 32'h2000, 16'd0, "R2 zero lines", 0);
        run_cmd(2'd0, 4'h7, 32'h2003, 16'd0, "R1 zero len unaligned", 0);
        run_cmd(2'd0, 4'h1, 32'h200F, 16'd1, "R1 one byte", 0);
        run_cmd(2'd0, 4'h1, 32'h200F, 16'd2, "R1 straddle", 0);
        run_cmd(2'd1, 4'h9, 32'h0, 16'd0, "R3 every way", 0);
        run_cmd(2'd2, 4'hC, 32'h0, 16'd0, "R4 one way", 0);
        run_cmd(2'd3, 4'h0, 32'h0, 16'd0, "R6 reset walk", 1);
        finish_run();
    end

endmodule